// File: doc/BRIEF.md
# Two-Tier Self-Repairing Cell Array Controller

This controller supervises a grid of reconfigurable cells. Each cell contains a few basic logic elements (BLEs), and each BLE is modelled only by a state code and a slot mapping; no configuration bits or routing are held here. While the array carries on with its normal work, the controller can test the BLEs in the background, one BLE per clock, and repair around any BLE that the per-BLE test-result inputs report as broken.

Repair happens in two tiers. In the first tier, the failing cell swaps in one of its own idle BLEs and points the affected function slot at it, with no central involvement. If the cell has no idle BLE left, it queues a single escalation. The central relocation engine then retires the whole cell and moves its function to the closest unused healthy cell, using grid distance. This move takes a fixed number of cycles and is reported through a relocation map. If no unused cell remains, the controller raises a permanent alarm.

Top module: `ftcell_ctrl`

## Requirements
- R1: After reset, every in-service cell has BLEs 0..BLES-2 active (code 0) and its last BLE spare (code 1), with function slot k mapped to BLE k. Cells flagged in IDLE_CELLS (default: cells 12..15) are out of service and have all BLEs spare. The relocation map is identity, scan_ptr is 0, and busy, esc_pending and unrecoverable are low. Cell index is row*COLS+col. Global BLE index is cell*BLES+b, and ble_fault uses the same bit index.
- R2: While test_n is high, scan_ptr holds and ble_fault has no effect on any state.
- R3: While test_n is low and no escalation is pending, scan_ptr advances by one per cycle and wraps from NB-1 to 0.
- R4: A scanned BLE that is already faulty (code 2), or that lies in a cell not in service, ignores its ble_fault bit.
- R5: A fault on a scanned active BLE in a cell that holds a spare makes that BLE faulty and the lowest-index spare active, and repoints the slot that used the failed BLE to the spare. This takes effect on the next cycle, without escalation.
- R6: A fault on a scanned spare BLE marks only that BLE faulty.
- R7: A fault on a scanned active BLE in a cell with no spare marks the BLE faulty and raises esc_pending on the next cycle. The scan stalls while esc_pending is high.
- R8: When the escalation is accepted (the cycle after esc_pending, if not busy), the source cell is retired, leaves service and has all its BLEs marked faulty. The target is the unused, non-retired cell at the smallest Manhattan distance, with ties going to the lowest cell index.
- R9: busy stays high for exactly RELOC_CYC cycles. As it falls, the target enters service with the R1 BLE pattern and identity slots, and reloc_to[src] becomes the target.
- R10: An escalation raised while busy waits in esc_pending and is accepted on the cycle after busy falls.
- R11: If no unused cell exists, the source is still retired, reloc_to is unchanged, busy stays low and unrecoverable sets and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_n | input | 1 | Active-low background-test enable |
| ble_fault | input | NB | Per-BLE test verdict, 1 = broken |
| ble_state | output | 2*NB | Per-BLE code: 0 active, 1 spare, 2 faulty |
| slot_map | output | NC*(BLES-1)*BW | Per-cell function slot to BLE index |
| reloc_to | output | NC*CW | Per-cell destination of its function |
| in_service | output | NC | Cell currently hosts a function |
| retired | output | NC | Cell permanently removed |
| scan_ptr | output | PW | BLE tested on the next edge |
| busy | output | 1 | Relocation in progress |
| esc_pending | output | 1 | Escalation queued |
| unrecoverable | output | 1 | Sticky: a relocation found no free cell |

## Verification
Two things can land on the same edge. A relocation can commit while the background scan, resumed during busy, detects a new spare-less fault that queues the next escalation. The bench arranges this by placing a second fault exactly four BLEs past the first, so the scan reaches it on the edge where busy falls. On the following cycle it checks that busy is low, esc_pending is high, the first target is in service, and that the second relocation starts one edge later toward the nearest remaining cell.

// File: rtl/ftcell_ctrl.sv
module ftcell_ctrl #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int BLES = 4,
  parameter int RELOC_CYC = 4,
  parameter logic [ROWS*COLS-1:0] IDLE_CELLS = 16'hF000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_n,
  input  logic [ROWS*COLS*BLES-1:0] ble_fault,
  output logic [2*ROWS*COLS*BLES-1:0] ble_state,
  output logic [ROWS*COLS*(BLES-1)*$clog2(BLES)-1:0] slot_map,
  output logic [ROWS*COLS*$clog2(ROWS*COLS)-1:0] reloc_to,
  output logic [ROWS*COLS-1:0] in_service,
  output logic [ROWS*COLS-1:0] retired,
  output logic [$clog2(ROWS*COLS*BLES)-1:0] scan_ptr,
  output logic busy,
  output logic esc_pending,
  output logic unrecoverable
);
  localparam int NC = ROWS * COLS;
  localparam int NB = NC * BLES;
  localparam int ACT = BLES - 1;
  localparam int BW = $clog2(BLES);
  localparam int CW = $clog2(NC);
  localparam int PW = $clog2(NB);
  localparam int TW = $clog2(RELOC_CYC + 1);
  localparam logic [1:0] ACTIVE = 2'd0, SPARE = 2'd1, FAULTY = 2'd2;

  logic [NB-1:0][1:0] st;
  logic [NC-1:0][ACT-1:0][BW-1:0] fm;
  logic [NC-1:0][CW-1:0] rt;
  logic [NC-1:0] svc, dead;
  logic [PW-1:0] ptr;
  logic pend_v, unrec;
  logic [CW-1:0] pend_c, src, dst, tgt;
  logic [TW-1:0] cnt;

  logic [CW-1:0] cur_c;
  logic [BW-1:0] cur_b, sp_idx, hit_k;
  logic sp_found, tgt_found, scan_go, hit_ok;

  assign cur_c = CW'(ptr / PW'(BLES));
  assign cur_b = BW'(ptr % PW'(BLES));
  assign scan_go = !test_n && !pend_v;
  assign hit_ok = svc[cur_c] && (st[ptr] != FAULTY) && ble_fault[ptr];

  always_comb begin
    sp_found = 1'b0;
    sp_idx = '0;
    for (int b = BLES - 1; b >= 0; b--)
      if (st[PW'(int'(cur_c) * BLES + b)] == SPARE) begin
        sp_found = 1'b1;
        sp_idx = BW'(b);
      end
    hit_k = '0;
    for (int k = 0; k < ACT; k++)
      if (fm[cur_c][k] == cur_b) hit_k = BW'(k);
  end

  always_comb begin
    int pr, pc, dr, dc, d, best;
    pr = int'(pend_c) / COLS;
    pc = int'(pend_c) % COLS;
    best = 0;
    tgt_found = 1'b0;
    tgt = '0;
    for (int i = 0; i < NC; i++) begin
      dr = (i / COLS > pr) ? i / COLS - pr : pr - i / COLS;
      dc = (i % COLS > pc) ? i % COLS - pc : pc - i % COLS;
      d = dr + dc;
      if (!svc[i] && !dead[i] && (!tgt_found || d < best)) begin
        tgt_found = 1'b1;
        tgt = CW'(i);
        best = d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      pend_v <= 1'b0;
      pend_c <= '0;
      busy <= 1'b0;
      cnt <= '0;
      src <= '0;
      dst <= '0;
      unrec <= 1'b0;
      for (int c = 0; c < NC; c++) begin
        svc[c] <= !IDLE_CELLS[c];
        dead[c] <= 1'b0;
        rt[c] <= CW'(c);
        for (int k = 0; k < ACT; k++) fm[c][k] <= BW'(k);
        for (int b = 0; b < BLES; b++)
          st[c*BLES+b] <= (IDLE_CELLS[c] || b == BLES - 1) ? SPARE : ACTIVE;
      end
    end else begin
      if (scan_go) begin
        ptr <= (ptr == PW'(NB - 1)) ? '0 : ptr + 1'b1;
        if (hit_ok) begin
          st[ptr] <= FAULTY;
          if (st[ptr] == ACTIVE) begin
            if (sp_found) begin
              st[PW'(int'(cur_c) * BLES + int'(sp_idx))] <= ACTIVE;
              fm[cur_c][hit_k] <= sp_idx;
            end else begin
              pend_v <= 1'b1;
              pend_c <= cur_c;
            end
          end
        end
      end
      if (pend_v && !busy) begin
        pend_v <= 1'b0;
        svc[pend_c] <= 1'b0;
        dead[pend_c] <= 1'b1;
        for (int b = 0; b < BLES; b++) st[PW'(int'(pend_c) * BLES + b)] <= FAULTY;
        if (tgt_found) begin
          busy <= 1'b1;
          cnt <= '0;
          src <= pend_c;
          dst <= tgt;
        end else begin
          unrec <= 1'b1;
        end
      end
      if (busy) begin
        if (cnt == TW'(RELOC_CYC - 1)) begin
          busy <= 1'b0;
          svc[dst] <= 1'b1;
          rt[src] <= dst;
          for (int b = 0; b < BLES; b++)
            st[PW'(int'(dst) * BLES + b)] <= (b == BLES - 1) ? SPARE : ACTIVE;
          for (int k = 0; k < ACT; k++) fm[dst][k] <= BW'(k);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign ble_state = st;
  assign slot_map = fm;
  assign reloc_to = rt;
  assign in_service = svc;
  assign retired = dead;
  assign scan_ptr = ptr;
  assign esc_pending = pend_v;
  assign unrecoverable = unrec;
endmodule

module ftcell_ctrl_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int BLES = 4,
  parameter int RELOC_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic test_n,
  input logic [2*ROWS*COLS*BLES-1:0] ble_state,
  input logic [ROWS*COLS-1:0] in_service,
  input logic [ROWS*COLS-1:0] retired,
  input logic [$clog2(ROWS*COLS*BLES)-1:0] scan_ptr,
  input logic busy,
  input logic esc_pending,
  input logic unrecoverable
);
  localparam int NB = ROWS * COLS * BLES;
  localparam int PW = $clog2(NB);
  localparam int RW = $clog2(RELOC_CYC + 2) + 1;

  logic [RW-1:0] run;
  logic [PW:0] nfault;
  logic [PW-1:0] exp_next;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else run <= busy ? run + 1'b1 : '0;
  end

  always_comb begin
    nfault = '0;
    for (int j = 0; j < NB; j++)
      if (ble_state[2*j +: 2] == 2'd2) nfault = nfault + 1'b1;
  end

  assign exp_next = (scan_ptr == PW'(NB - 1)) ? '0 : scan_ptr + 1'b1;

  assert_hold_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |=> $stable(scan_ptr));
  assert_scan_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_n && !esc_pending) |=> scan_ptr == $past(exp_next));
  assert_fault_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nfault >= $past(nfault));
  assert_queue_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    esc_pending |=> $stable(scan_ptr));
  assert_retired_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retired & in_service) == '0);
  assert_retired_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retired) & ~retired) == '0);
  assert_busy_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RW'(RELOC_CYC));
  assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(run) == RW'(RELOC_CYC - 1));
  assert_unrec_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |=> unrecoverable);
endmodule

bind ftcell_ctrl ftcell_ctrl_chk #(
  .ROWS(ROWS), .COLS(COLS), .BLES(BLES), .RELOC_CYC(RELOC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .test_n(test_n), .ble_state(ble_state),
  .in_service(in_service), .retired(retired), .scan_ptr(scan_ptr),
  .busy(busy), .esc_pending(esc_pending), .unrecoverable(unrecoverable)
);

// File: tb/tb_ftcell_ctrl.sv
module tb_ftcell_ctrl;
  localparam int ROWS = 4, COLS = 4, BLES = 4, RC = 4;
  localparam int NC = 16, NB = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, test_n;
  logic [NB-1:0] ble_fault;
  logic [2*NB-1:0] ble_state;
  logic [NC*3*2-1:0] slot_map;
  logic [NC*4-1:0] reloc_to;
  logic [NC-1:0] in_service, retired;
  logic [5:0] scan_ptr;
  logic busy, esc_pending, unrecoverable;

  ftcell_ctrl #(.ROWS(ROWS), .COLS(COLS), .BLES(BLES), .RELOC_CYC(RC),
                .IDLE_CELLS(16'hF000)) dut (
    .clk(clk), .rst_n(rst_n), .test_n(test_n), .ble_fault(ble_fault),
    .ble_state(ble_state), .slot_map(slot_map), .reloc_to(reloc_to),
    .in_service(in_service), .retired(retired), .scan_ptr(scan_ptr),
    .busy(busy), .esc_pending(esc_pending), .unrecoverable(unrecoverable));

  int pass_n = 0, fail_n = 0;
  bit done = 1'b0;
  logic [NC-1:0] idle_m;
  logic [2*NB-1:0] snap;

  function automatic int st(int j); return int'(ble_state[2*j +: 2]); endfunction
  function automatic int sl(int c, int k); return int'(slot_map[(c*3+k)*2 +: 2]); endfunction
  function automatic int rl(int c); return int'(reloc_to[c*4 +: 4]); endfunction

  function automatic int nearest(int c);
    int best, bd, d;
    best = -1; bd = 0;
    for (int i = 0; i < NC; i++) begin
      d = ((i/COLS > c/COLS) ? i/COLS - c/COLS : c/COLS - i/COLS)
        + ((i%COLS > c%COLS) ? i%COLS - c%COLS : c%COLS - i%COLS);
      if (idle_m[i] && (best < 0 || d < bd)) begin best = i; bd = d; end
    end
    return best;
  endfunction

  task automatic chk(string tag, int act, int exp);
    if (act == exp) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic hit(int j);
    ble_fault = '0; ble_fault[j] = 1'b1; test_n = 1'b0;
    while (int'(scan_ptr) != j) step();
    step();
    test_n = 1'b1; ble_fault = '0;
  endtask

  task automatic fresh(string tag, int c);
    for (int b = 0; b < BLES; b++) chk(tag, st(c*4+b), (b == 3) ? 1 : 0);
    for (int k = 0; k < 3; k++) chk(tag, sl(c, k), k);
  endtask

  task automatic relocate_full(int c);
    int t;
    t = nearest(c);
    hit(c*4);
    chk("R7 pending", int'(esc_pending), 1);
    chk("R7 bad BLE", st(c*4), 2);
    step();
    chk("R8 retired", int'(retired[c]), 1);
    chk("R8 out", int'(in_service[c]), 0);
    for (int b = 0; b < BLES; b++) chk("R8 src faulty", st(c*4+b), 2);
    for (int n = 0; n < RC; n++) begin
      chk("R9 busy", int'(busy), 1);
      chk("R9 target not yet", int'(in_service[t]), 0);
      step();
    end
    chk("R9 busy fall", int'(busy), 0);
    chk("R9 target in", int'(in_service[t]), 1);
    chk("R9 map", rl(c), t);
    fresh("R9 fresh", t);
    idle_m[t] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fail_n++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
    end
  end

  initial begin
    int t9, t10;
    rst_n = 1'b0; test_n = 1'b1; ble_fault = '0;
    idle_m = 16'hF000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < BLES; b++) chk("R1 state", st(c*4+b), (c >= 12 || b == 3) ? 1 : 0);
      for (int k = 0; k < 3; k++) chk("R1 slot", sl(c, k), k);
      chk("R1 reloc", rl(c), c);
      chk("R1 svc", int'(in_service[c]), (c >= 12) ? 0 : 1);
    end
    chk("R1 ptr", int'(scan_ptr), 0);
    chk("R1 flags", int'({busy, esc_pending, unrecoverable}), 0);

    // R2 normal mode ignores faults
    snap = ble_state;
    ble_fault = '1;
    repeat (20) step();
    chk("R2 ptr", int'(scan_ptr), 0);
    chk("R2 state", int'(ble_state == snap), 1);
    chk("R2 pending", int'(esc_pending), 0);
    ble_fault = '0;

    // R3 scan sweep with wrap
    test_n = 1'b0;
    for (int k = 1; k <= 67; k++) begin
      step();
      chk("R3 ptr", int'(scan_ptr), k % NB);
    end
    test_n = 1'b1;

    // R6 spare fault in cell 11
    hit(47);
    chk("R6 spare faulty", st(47), 2);
    for (int b = 0; b < 3; b++) chk("R6 others", st(44+b), 0);
    for (int k = 0; k < 3; k++) chk("R6 slots", sl(11, k), k);
    chk("R6 pending", int'(esc_pending), 0);

    // R5 local swap sweep, slot 1 of cells 0..10
    for (int c = 0; c <= 10; c++) begin
      hit(c*4+1);
      chk("R5 failed", st(c*4+1), 2);
      chk("R5 spare used", st(c*4+3), 0);
      chk("R5 slot1", sl(c, 1), 3);
      chk("R5 slot0", sl(c, 0), 0);
      chk("R5 slot2", sl(c, 2), 2);
      chk("R5 BLE0", st(c*4), 0);
      chk("R5 no esc", int'(esc_pending), 0);
    end

    // R4 skip idle-cell BLE and already-faulty BLE
    hit(48);
    chk("R4 idle cell", st(48), 1);
    chk("R4 idle no esc", int'(esc_pending), 0);
    hit(1);
    chk("R4 faulty skip", st(1), 2);
    chk("R4 slot kept", sl(0, 1), 3);
    chk("R4 no esc", int'(esc_pending), 0);

    // R7 R8 R9 escalation of cell 5
    relocate_full(5);
    chk("R8 cell5 target", rl(5), 13);

    // R10 overlap: commit of cell 9 and new escalation of cell 10 on same edge
    t9 = nearest(9);
    chk("R8 tie lowest", t9, 12);
    ble_fault = '0; ble_fault[36] = 1'b1; ble_fault[40] = 1'b1; test_n = 1'b0;
    while (int'(scan_ptr) != 36) step();
    step();
    chk("R7 pend9", int'(esc_pending), 1);
    chk("R7 ptr37", int'(scan_ptr), 37);
    step();
    chk("R8 busy9", int'(busy), 1);
    chk("R7 stalled", int'(scan_ptr), 37);
    chk("R8 ret9", int'(retired[9]), 1);
    step(); step(); step();
    chk("R10 scan during busy", int'(scan_ptr), 40);
    chk("R10 busy", int'(busy), 1);
    step();
    chk("R10 busy fall", int'(busy), 0);
    chk("R10 queued", int'(esc_pending), 1);
    chk("R9 map9", rl(9), t9);
    chk("R9 svc t9", int'(in_service[t9]), 1);
    chk("R10 ptr41", int'(scan_ptr), 41);
    idle_m[t9] = 1'b0;
    t10 = nearest(10);
    step();
    test_n = 1'b1; ble_fault = '0;
    chk("R10 accepted", int'(busy), 1);
    chk("R10 ret10", int'(retired[10]), 1);
    step(); step(); step();
    chk("R10 still busy", int'(busy), 1);
    step();
    chk("R10 done", int'(busy), 0);
    chk("R10 map10", rl(10), t10);
    chk("R10 target14", t10, 14);
    idle_m[t10] = 1'b0;

    // last idle cell, then exhaustion
    relocate_full(0);
    chk("R8 cell0 target", rl(0), 15);
    hit(4);
    chk("R11 pending", int'(esc_pending), 1);
    step();
    chk("R11 unrec", int'(unrecoverable), 1);
    chk("R11 no busy", int'(busy), 0);
    chk("R11 retired", int'(retired[1]), 1);
    chk("R11 map kept", rl(1), 1);
    repeat (10) step();
    chk("R11 sticky", int'(unrecoverable), 1);
    chk("R11 no busy later", int'(busy), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule